// File: doc/BRIEF.md
# Reversible Full Adder Cascade

This block is a one-bit full adder made only from reversible three-line gates. Each gate maps its three input lines one-to-one onto three output lines. Two such gates are chained. The first gate takes the addend bits and a constant-zero helper line. The second gate takes what the first produced, together with the carry-in. Every gate output goes to exactly one place, either the next gate or a port, and nothing loops back.

There are four inputs: the two addend bits, the carry-in and the helper line. There are four outputs: sum, carry-out and two leftover lines. The leftover lines are a copy of the first addend and the exclusive-or of the two addends. Because the four-bit input vector and the four-bit output vector are related one-to-one, the inputs can always be recovered from the outputs. In normal use the helper line is tied low. If it is driven high, only the carry-out is inverted.

Each gate computes `(x, y, z) -> (x, x^y, (x&y)^z)`. This is a controlled-NOT from the first line to the second, merged with a doubly controlled NOT from the first two lines onto the third.

Top module: `rfa_cascade`

## Requirements
- R1: `sum` equals `a ^ b ^ cin` for every value of `anc`.
- R2: With `anc` = 0, `cout` is 1 exactly when at least two of `a`, `b`, `cin` are 1.
- R3: With `anc` = 0, the two-bit value `{cout, sum}` equals the integer sum `a + b + cin`, for all 8 combinations.
- R4: Leftover output `g1` always equals `a`.
- R5: Leftover output `g2` always equals `a ^ b`.
- R6: Driving `anc` = 1 inverts `cout` relative to its `anc` = 0 value and leaves `sum`, `g1` and `g2` unchanged.
- R7: Over all 16 values of `{a, b, cin, anc}`, the output vector `{g1, g2, sum, cout}` takes 16 distinct values.
- R8: The inputs can be rebuilt from the outputs alone: `a = g1`, `b = g1 ^ g2`, `cin = g2 ^ sum`, and `anc = cout ^ majority(a, b, cin)`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a | input | 1 | First addend bit |
| b | input | 1 | Second addend bit |
| cin | input | 1 | Carry-in |
| anc | input | 1 | Helper line, tied to 0 in normal use |
| sum | output | 1 | Sum bit |
| cout | output | 1 | Carry-out bit, inverted when `anc` is 1 |
| g1 | output | 1 | Leftover line, copy of `a` |
| g2 | output | 1 | Leftover line, `a ^ b` |

## Verification
The bench applies all eight addend and carry-in combinations with the helper line low, and scores each one against integer addition. A cascade that took its carry from the wrong gate line would give a wrong carry for the mixed-input cases, such as 1+0+1. It then drives the helper line high for all eight combinations. A design that fed the helper line into the sum path, instead of into the product line, would fail there by disturbing `sum` or leaving `cout` uninverted. Finally, the bench collects all sixteen output vectors and checks that they are distinct and that each one decodes back to the inputs that produced it. A leftover line that was dropped, or a gate that loses information, would merge two input vectors into one output vector.

// File: rtl/rfa_pkg.sv
package rfa_pkg;
  localparam int LINES = 3;

  typedef logic [LINES-1:0] line_vec_t;

  // Forward map: line 2 is the control, line 1 is the controlled-NOT target,
  // line 0 is the doubly controlled target.
  function automatic line_vec_t gate_fwd(input line_vec_t x);
    line_vec_t y;
    y[2] = x[2];
    y[1] = x[2] ^ x[1];
    y[0] = (x[2] & x[1]) ^ x[0];
    return y;
  endfunction

  // Inverse map: rebuilds the gate inputs from its outputs.
  function automatic line_vec_t gate_inv(input line_vec_t y);
    line_vec_t x;
    x[2] = y[2];
    x[1] = y[2] ^ y[1];
    x[0] = (y[2] & x[1]) ^ y[0];
    return x;
  endfunction

  function automatic logic majority3(input logic p, input logic q, input logic r);
    return (p & q) | (q & r) | (r & p);
  endfunction
endpackage

// File: rtl/rfa_gate3.sv
module rfa_gate3
  import rfa_pkg::*;
(
  input  line_vec_t lines_in,
  output line_vec_t lines_out
);
  assign lines_out = gate_fwd(lines_in);
endmodule

// File: rtl/rfa_cascade.sv
module rfa_cascade
  import rfa_pkg::*;
#(
  parameter int STAGES = 2
) (
  input  logic a,
  input  logic b,
  input  logic cin,
  input  logic anc,
  output logic sum,
  output logic cout,
  output logic g1,
  output logic g2
);
  localparam int LAST = STAGES - 1;

  line_vec_t st_in  [STAGES];
  line_vec_t st_out [STAGES];

  // Named links between the gates, brought out for the checker.
  logic lnk_xor_ab;
  logic lnk_and_ab;

  assign st_in[0] = {a, b, anc};

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      rfa_gate3 u_gate (
        .lines_in  (st_in[s]),
        .lines_out (st_out[s])
      );
    end
  endgenerate

  assign lnk_xor_ab = st_out[0][1];
  assign lnk_and_ab = st_out[0][0];

  // Each gate output is routed to exactly one place.
  // Line 2 of stage 0 leaves as g1; lines 1 and 0 feed stage 1.
  assign st_in[LAST] = {lnk_xor_ab, cin, lnk_and_ab};

  assign g1   = st_out[0][2];
  assign g2   = st_out[LAST][2];
  assign sum  = st_out[LAST][1];
  assign cout = st_out[LAST][0];
endmodule

// File: rtl/rfa_cascade_chk.sv
module rfa_cascade_chk
  import rfa_pkg::*;
(
  input logic a,
  input logic b,
  input logic cin,
  input logic anc,
  input logic sum,
  input logic cout,
  input logic g1,
  input logic g2,
  input logic lnk_xor_ab,
  input logic lnk_and_ab
);
  always_comb begin
    // R1
    a_r1_sum_parity: assert (sum == (a ^ b ^ cin))
      else $error("R1 sum parity");
    // R2, R6
    a_r2_carry_majority: assert ((cout ^ anc) == majority3(a, b, cin))
      else $error("R2 carry majority");
    // R4
    a_r4_g1_copy: assert (g1 == a)
      else $error("R4 g1 copy");
    // R5
    a_r5_g2_link: assert (g2 == lnk_xor_ab && lnk_xor_ab == (a ^ b))
      else $error("R5 g2 link");
    // R8
    a_r8_inverse: assert (gate_inv({g2, sum, cout}) == {lnk_xor_ab, cin, lnk_and_ab})
      else $error("R8 inverse");
  end
endmodule

bind rfa_cascade rfa_cascade_chk u_chk (
  .a          (a),
  .b          (b),
  .cin        (cin),
  .anc        (anc),
  .sum        (sum),
  .cout       (cout),
  .g1         (g1),
  .g2         (g2),
  .lnk_xor_ab (lnk_xor_ab),
  .lnk_and_ab (lnk_and_ab)
);

// File: tb/rfa_cascade_test.sv
module rfa_cascade_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic a = 1'b0, b = 1'b0, cin = 1'b0, anc = 1'b0;
  logic sum, cout, g1, g2;

  rfa_cascade uut (
    .a(a), .b(b), .cin(cin), .anc(anc),
    .sum(sum), .cout(cout), .g1(g1), .g2(g2)
  );

  typedef struct {
    logic [3:0] vin;   // {a, b, cin, anc}
    logic [3:0] vexp;  // {g1, g2, sum, cout}
  } item_t;

  item_t sb_q[$];
  int n_chk = 0;
  int n_bad = 0;
  bit seen [16];
  int collected = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  // Driver: expected values come from integer addition.
  task automatic drive(input logic [3:0] v);
    item_t it;
    int total;
    @(posedge clk);
    #1;
    {a, b, cin, anc} = v;
    total = int'(v[3]) + int'(v[2]) + int'(v[1]);
    it.vin  = v;
    it.vexp = {v[3], v[3] ^ v[2], total[0], total[1] ^ v[0]};
    sb_q.push_back(it);
  endtask

  // Monitor: samples at the falling edge.
  always @(negedge clk) begin
    if (!rst && sb_q.size() > 0) begin
      item_t it;
      int total;
      logic [3:0] rebuilt;
      it = sb_q.pop_front();
      check("R1 sum", {3'b0, sum}, {3'b0, it.vexp[1]});
      if (it.vin[0] == 1'b0) begin
        check("R2 carry", {3'b0, cout}, {3'b0, it.vexp[0]});
        total = int'(it.vin[3]) + int'(it.vin[2]) + int'(it.vin[1]);
        check("R3 add", {2'b0, cout, sum}, total[3:0]);
      end else begin
        check("R6 anc inverts carry", {g1, g2, sum, cout}, it.vexp);
      end
      check("R4 g1", {3'b0, g1}, {3'b0, it.vexp[3]});
      check("R5 g2", {3'b0, g2}, {3'b0, it.vexp[2]});
      rebuilt[3] = g1;
      rebuilt[2] = g1 ^ g2;
      rebuilt[1] = g2 ^ sum;
      rebuilt[0] = cout ^ ((rebuilt[3] & rebuilt[2]) | (rebuilt[2] & rebuilt[1]) | (rebuilt[1] & rebuilt[3]));
      check("R8 rebuild", rebuilt, it.vin);
      if (!seen[{g1, g2, sum, cout}]) begin
        seen[{g1, g2, sum, cout}] = 1'b1;
        collected++;
      end
    end
  end

  int wd = 0;
  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 5000 && !done) begin
      done = 1'b1;
      n_bad++;
      n_chk++;
      $display("FAIL watchdog actual=%0d expected<=5000", wd);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R3 reset zero inputs", {g1, g2, sum, cout}, 4'b0000);
    rst = 1'b0;
    // Helper line low: the eight adder cases (R3).
    for (int i = 0; i < 8; i++) drive({i[2:0], 1'b0});
    // Helper line high: carry inverts only (R6).
    for (int i = 0; i < 8; i++) drive({i[2:0], 1'b1});
    // A few repeated mixed patterns.
    drive(4'b1010);
    drive(4'b0111);
    drive(4'b1100);
    repeat (3) @(posedge clk);
    check("R7 distinct outputs", collected[3:0], 4'd0);
    n_chk++;
    if (collected != 16) begin
      n_bad++;
      $display("FAIL R7 distinct count actual=%0d expected=16", collected);
    end
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule